// File: doc/BRIEF.md
# Fixed-Length Sample Delay Line

This block holds 8-bit audio samples in a circular memory whose length never changes during operation. Every sample strobe reads out the sample stored at the current slot, stores the new input in that slot, and moves on to the next slot. A sample therefore comes back out after exactly one trip around the buffer. The delay in seconds is the buffer length divided by the strobe rate. To lengthen or shorten the echo, the system changes the strobe rate. No read offset is moved.

A two-bit depth code chooses how much of the memory is used: a quarter of it, half of it, or all of it. Builds with a smaller memory can then share the same logic. With `ADDR_W` = 18 the full depth is 262144 samples. At a strobe rate of 32.9 kHz that gives a delay of about 7.96 s, and at 261.1 kHz about 1.0 s. The output flag stays low until one full pass of the selected depth has been written, so stale memory is never reported as a valid sample.

Top module: `sdly_line`

## Requirements
- R1: Each output sample equals the input sample accepted exactly D strobes earlier, where D is the depth in use. The slot index runs 0 to D-1 and then wraps to 0.
- R2: The depth code sets D as follows: 0 gives 2^(ADDR_W-2), 1 gives 2^(ADDR_W-1), and both 2 and 3 give 2^ADDR_W.
- R3: Delay is counted only in strobes. Clock cycles without a strobe leave `smp_out`, `smp_out_vld` and the slot index unchanged.
- R4: After a reset or restart, `smp_out_vld` stays 0 through the first D strobes. It goes to 1 with the output of strobe D+1 and then stays at 1 until the next reset or restart.
- R5: `smp_out` and `smp_out_vld` are registered. They change on the clock edge that follows the edge on which the strobe was sampled.
- R6: A synchronous `rst` that is high on a clock edge sets `smp_out` to 0, sets `smp_out_vld` to 0 and sets the slot index to 0. A strobe present during reset is discarded.
- R7: If `depth_sel` differs from the code latched at the previous edge, that edge acts as a restart. The new code is latched, `smp_out` and `smp_out_vld` go to 0, the slot index returns to 0, and any strobe in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_in | input | DATA_W | Sample to store |
| depth_sel | input | 2 | Depth code (see R2) |
| smp_out | output | DATA_W | Delayed sample |
| smp_out_vld | output | 1 | High once `smp_out` holds a real delayed sample |

## Verification
The assertions check four things on every cycle:
- Outputs and slot index hold still when there is no strobe.
- The valid flag stays high once it is set.
- The slot index stays inside the selected depth.
- A restart clears the state, and the flag first rises only on a strobe at slot 0.

Some behaviour can only be shown by the bench's scenarios, because they compare against a queue model. These are:
- The end-to-end data identity after exactly D strobes, under dense, sparse and irregular strobe patterns.
- The exact fill length for each depth code.
- Dropping a strobe that coincides with reset or with a depth change.

// File: rtl/sdly_pkg.sv
package sdly_pkg;

  typedef enum logic [1:0] {
    DEPTH_QUARTER = 2'd0,
    DEPTH_HALF    = 2'd1,
    DEPTH_FULL    = 2'd2,
    DEPTH_FULL_B  = 2'd3
  } depth_sel_e;

  // Right shift that is applied to the full address mask for each code
  function automatic int unsigned depth_shift(input logic [1:0] sel);
    case (depth_sel_e'(sel))
      DEPTH_QUARTER: depth_shift = 2;
      DEPTH_HALF:    depth_shift = 1;
      default:       depth_shift = 0;
    endcase
  endfunction

endpackage

// File: rtl/sdly_ptr.sv
module sdly_ptr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              advance,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] ptr,
  output logic              at_last
);

  logic [ADDR_W-1:0] ptr_nxt;

  assign ptr_nxt = (ptr + 1'b1) & mask;
  assign at_last = (ptr == mask);

  always_ff @(posedge clk) begin
    if (clr) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= ptr_nxt;
    end
  end

endmodule

// File: rtl/sdly_ram.sv
module sdly_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Write port: the array has no reset, so it maps to block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      mem[addr] <= wdata;
    end
  end

  // Read-first output register with a synchronous clear
  always_ff @(posedge clk) begin
    if (clr) begin
      rdata <= '0;
    end else if (en) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/sdly_fill.sv
module sdly_fill (
  input  logic clk,
  input  logic clr,
  input  logic advance,
  input  logic at_last,
  output logic vld
);

  logic armed;

  always_ff @(posedge clk) begin
    if (clr) begin
      armed <= 1'b0;
      vld   <= 1'b0;
    end else if (advance) begin
      if (at_last) begin
        armed <= 1'b1;
      end
      if (armed) begin
        vld <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdly_line.sv
module sdly_line #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_in,
  input  logic [1:0]        depth_sel,
  output logic [DATA_W-1:0] smp_out,
  output logic              smp_out_vld
);

  import sdly_pkg::*;

  localparam logic [ADDR_W-1:0] FULL_MASK = '1;

  generate
    if (ADDR_W < 3) begin : g_bad_width
      initial $error("sdly_line: ADDR_W must be at least 3");
    end
  endgenerate

  logic [1:0]        cfg_q;
  logic              restart;
  logic              clr;
  logic              advance;
  logic [ADDR_W-1:0] ptr_mask;
  logic [ADDR_W-1:0] wr_ptr;
  logic              ptr_last;

  always_ff @(posedge clk) begin
    cfg_q <= depth_sel;
  end

  assign restart  = !rst && (depth_sel != cfg_q);
  assign clr      = rst || restart;
  assign advance  = smp_stb && !clr;
  assign ptr_mask = FULL_MASK >> depth_shift(cfg_q);

  sdly_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .clr     (clr),
    .advance (advance),
    .mask    (ptr_mask),
    .ptr     (wr_ptr),
    .at_last (ptr_last)
  );

  sdly_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .clr   (clr),
    .en    (advance),
    .addr  (wr_ptr),
    .wdata (smp_in),
    .rdata (smp_out)
  );

  sdly_fill u_fill (
    .clk     (clk),
    .clr     (clr),
    .advance (advance),
    .at_last (ptr_last),
    .vld     (smp_out_vld)
  );

endmodule

// File: rtl/sdly_line_chk.sv
module sdly_line_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              stb,
  input logic              restart,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] ptr_mask,
  input logic [DATA_W-1:0] dout,
  input logic              vld
);

  // R3: no strobe means nothing moves
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!stb && !restart) |=> ($stable(dout) && $stable(vld) && $stable(ptr)));

  // R4: once set, the flag stays set until a clear
  p_vld_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (vld && !restart) |=> vld);

  // R4: the flag first rises after a strobe taken at slot 0
  p_vld_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(vld) |-> ($past(stb) && ($past(ptr) == '0)));

  // R7: a depth change clears the state
  p_restart_clear_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!vld && (dout == '0) && (ptr == '0)));

  // R2: the slot index stays inside the selected depth
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (rst)
    ((ptr & ~ptr_mask) == '0));

endmodule

bind sdly_line sdly_line_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stb      (smp_stb),
  .restart  (restart),
  .ptr      (wr_ptr),
  .ptr_mask (ptr_mask),
  .dout     (smp_out),
  .vld      (smp_out_vld)
);

// File: tb/sdly_line_tb.sv
module sdly_line_tb;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_stb = 1'b0;
  logic [DATA_W-1:0] smp_in = '0;
  logic [1:0]        depth_sel = 2'd2;
  logic [DATA_W-1:0] smp_out;
  logic              smp_out_vld;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  string data_tag = "R1";

  // Behavioural reference model
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] exp_out = '0;
  logic              exp_vld = 1'b0;
  logic [1:0]        cfg_m = 2'd2;

  always #10 clk = ~clk;

  sdly_line #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_in(smp_in),
    .depth_sel(depth_sel), .smp_out(smp_out), .smp_out_vld(smp_out_vld)
  );

  function automatic int depth_of(input logic [1:0] c);
    if (c == 2'd0) return 1 << (ADDR_W - 2);
    if (c == 2'd1) return 1 << (ADDR_W - 1);
    return 1 << ADDR_W;
  endfunction

  always @(posedge clk) begin
    if (rst || depth_sel != cfg_m) begin
      q.delete();
      exp_out = '0;
      exp_vld = 1'b0;
      cfg_m = depth_sel;
    end else if (smp_stb) begin
      q.push_back(smp_in);
      if (q.size() > depth_of(cfg_m)) begin
        exp_out = q.pop_front();
        exp_vld = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge (R5: outputs already updated)
  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check("R4 R5 valid", {31'd0, smp_out_vld}, {31'd0, exp_vld});
      if (exp_vld) check({data_tag, " R5 data"}, {24'd0, smp_out}, {24'd0, exp_out});
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_stb = 1'b0;
    end
  endtask

  // gap: idle cycles after each strobe; gap < 0 picks a random gap 0..4
  task automatic stream(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_stb = 1'b1;
      smp_in = DATA_W'($urandom);
      @(negedge clk);
      smp_stb = 1'b0;
      idle(gap < 0 ? int'($urandom_range(0, 4)) : gap);
    end
  endtask

  // R2: count strobes until valid rises; expect D+1
  task automatic fill_len(input logic [1:0] code);
    int n = 0;
    @(negedge clk);
    depth_sel = code;
    smp_stb = 1'b0;
    @(negedge clk);
    check("R7 clear vld", {31'd0, smp_out_vld}, 32'd0);
    check("R7 clear data", {24'd0, smp_out}, 32'd0);
    while (!smp_out_vld && n < 200) begin
      smp_stb = 1'b1;
      smp_in = DATA_W'($urandom);
      @(negedge clk);
      smp_stb = 1'b0;
      n++;
    end
    check("R2 R4 fill length", n, depth_of(code) + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset vld", {31'd0, smp_out_vld}, 32'd0);
    check("R6 reset data", {24'd0, smp_out}, 32'd0);
    rst = 1'b0;
    cmp_on = 1'b1;

    data_tag = "R1";
    stream(200, 0);

    data_tag = "R3";
    stream(150, 2);
    stream(150, -1);

    data_tag = "R2";
    fill_len(2'd0);
    stream(60, -1);
    fill_len(2'd1);
    stream(80, 1);
    fill_len(2'd3);
    stream(80, -1);
    fill_len(2'd2);

    // R3: long idle leaves the output untouched
    begin
      logic [DATA_W-1:0] held;
      held = smp_out;
      idle(25);
      check("R3 idle hold", {24'd0, smp_out}, {24'd0, held});
    end

    // R7: strobe coincident with a depth change is discarded
    data_tag = "R7";
    @(negedge clk);
    depth_sel = 2'd0;
    smp_stb = 1'b1;
    smp_in = 8'hA5;
    @(negedge clk);
    smp_stb = 1'b0;
    check("R7 restart vld", {31'd0, smp_out_vld}, 32'd0);
    stream(70, -1);

    // R6: reset mid-stream with strobe held high
    @(negedge clk);
    rst = 1'b1;
    smp_stb = 1'b1;
    smp_in = 8'h3C;
    @(negedge clk);
    smp_stb = 1'b0;
    rst = 1'b0;
    check("R6 mid reset vld", {31'd0, smp_out_vld}, 32'd0);
    check("R6 mid reset data", {24'd0, smp_out}, 32'd0);
    data_tag = "R6";
    stream(40, 0);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule